// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This unit takes a byte, word or long operand and moves it by exactly one bit position, or inverts it. Eight movement flavours are available: logical and arithmetic shifts in both directions, plain rotates in both directions, and rotates through the carry flag in both directions. A ninth operation is the bitwise complement. The unit also produces the four condition flags that an integer datapath needs after such an operation: carry, negative, zero and overflow.

The result and flags are registered. The unit returns them one clock after the operand, size, operation and incoming carry are presented. A new operation can be issued on every cycle. Only the low 8, 16 or 32 bits of the operand take part. For narrower sizes, the result is returned zero-extended to 32 bits. Multi-position shifting and register-file access are left to surrounding logic.

Top module: `ssr_unit`

## Requirements
- R1: The result and all four flags appear on the outputs on the first rising clock edge after the inputs are applied. While reset is asserted (rst_n low), the result and all flags are zero.
- R2: size_i selects the width: 0 is byte (8 bits), 1 is word (16 bits), 2 and 3 are long (32 bits). Result bits above the selected width are always zero.
- R3: op_i 1 (logical left) and op_i 3 (arithmetic left) shift the operand left by one and fill bit 0 with zero. The operand's top bit at the selected width goes to C.
- R4: op_i 2 (logical right) fills the top bit with zero. op_i 4 (arithmetic right) keeps the top bit at its old value. In both, operand bit 0 goes to C.
- R5: op_i 5 (rotate left) puts the old top bit into both bit 0 and C. op_i 6 (rotate right) puts old bit 0 into both the top bit and C.
- R6: op_i 7 (rotate left through carry) fills bit 0 with carry_i, and the old top bit becomes C. op_i 8 (rotate right through carry) fills the top bit with carry_i, and old bit 0 becomes C.
- R7: op_i 0 (complement) inverts every bit within the selected width. C then equals carry_i.
- R8: For op_i 0 to 8, V is cleared, N equals the result's top bit at the selected width, and Z is set exactly when the result is zero at that width.
- R9: For op_i 9 to 15, the result is the operand masked to the selected width, C equals carry_i, and N, Z and V keep the values they had before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_i | input | 32 | Operand |
| size_i | input | 2 | Width select (0 byte, 1 word, 2/3 long) |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Result, zero-extended above the selected width |
| flag_c_o | output | 1 | Carry flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
Every result and every flag is due exactly one rising edge after its inputs. This holds even for the held N, Z and V of the unused codes: each holds over the edge that follows its own stimulus. The bench drives each operation on a falling edge and compares on the next falling edge, which comes just after the capturing rising edge. At that same falling edge it applies the next operation, so back-to-back issue is exercised throughout. The reference model carries its own copy of the last N, Z and V, so that the hold behaviour of the unused codes is predicted rather than read back from the design.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int SSR_DATA_W = 32;

    typedef enum logic [3:0] {
        OP_INVERT = 4'd0,
        OP_SHL_LOG = 4'd1,
        OP_SHR_LOG = 4'd2,
        OP_SHL_ARI = 4'd3,
        OP_SHR_ARI = 4'd4,
        OP_ROL = 4'd5,
        OP_ROR = 4'd6,
        OP_ROL_C = 4'd7,
        OP_ROR_C = 4'd8
    } ssr_op_e;

    typedef struct packed {
        logic [SSR_DATA_W-1:0] res;
        logic c;
        logic n;
        logic z;
        logic v;
    } ssr_state_t;

endpackage

// File: rtl/ssr_lane.sv
module ssr_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a_i,
    input  logic [3:0]    op_i,
    input  logic          cin_i,
    output logic [LW-1:0] r_o,
    output logic          c_o
);
    import ssr_pkg::*;

    logic msb;
    logic lsb;

    assign msb = a_i[LW-1];
    assign lsb = a_i[0];

    always_comb begin
        r_o = a_i;
        c_o = cin_i;
        case (ssr_op_e'(op_i))
            OP_INVERT: begin
                r_o = ~a_i;
                c_o = cin_i;
            end
            OP_SHL_LOG, OP_SHL_ARI: begin
                r_o = {a_i[LW-2:0], 1'b0};
                c_o = msb;
            end
            OP_SHR_LOG: begin
                r_o = {1'b0, a_i[LW-1:1]};
                c_o = lsb;
            end
            OP_SHR_ARI: begin
                r_o = {msb, a_i[LW-1:1]};
                c_o = lsb;
            end
            OP_ROL: begin
                r_o = {a_i[LW-2:0], msb};
                c_o = msb;
            end
            OP_ROR: begin
                r_o = {lsb, a_i[LW-1:1]};
                c_o = lsb;
            end
            OP_ROL_C: begin
                r_o = {a_i[LW-2:0], cin_i};
                c_o = msb;
            end
            OP_ROR_C: begin
                r_o = {cin_i, a_i[LW-1:1]};
                c_o = lsb;
            end
            default: begin
                r_o = a_i;
                c_o = cin_i;
            end
        endcase
    end

endmodule

// File: rtl/ssr_flags.sv
module ssr_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        sel_i,
    output logic              neg_o,
    output logic              zero_o
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    always_comb begin
        case (sel_i)
            2'd0:    neg_o = res_i[BYTE_W-1];
            2'd1:    neg_o = res_i[WORD_W-1];
            default: neg_o = res_i[DATA_W-1];
        endcase
        zero_o = (res_i == '0);
    end

endmodule

// File: rtl/ssr_unit.sv
module ssr_unit #(
    parameter int DATA_W = ssr_pkg::SSR_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        size_i,
    input  logic [3:0]        op_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              flag_c_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o
);
    import ssr_pkg::*;

    localparam int BYTE_W    = DATA_W / 4;
    localparam int NUM_SIZES = 3;

    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    logic              lane_c   [NUM_SIZES];
    logic [1:0]        sel;
    logic              op_known;
    logic              pick_n;
    logic              pick_z;
    ssr_state_t        st_d;
    ssr_state_t        st_q;

    assign sel      = (size_i == 2'd3) ? 2'd2 : size_i;
    assign op_known = (op_i <= 4'(OP_ROR_C));

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = BYTE_W << g;
        logic [LW-1:0] r_nar;

        ssr_lane #(.LW(LW)) i_lane (
            .a_i   (opnd_i[LW-1:0]),
            .op_i  (op_i),
            .cin_i (carry_i),
            .r_o   (r_nar),
            .c_o   (lane_c[g])
        );

        if (LW < DATA_W) begin : g_ext
            assign lane_res[g] = {{(DATA_W-LW){1'b0}}, r_nar};
        end else begin : g_full
            assign lane_res[g] = r_nar;
        end
    end

    ssr_flags #(.DATA_W(DATA_W)) i_flags (
        .res_i  (lane_res[sel]),
        .sel_i  (sel),
        .neg_o  (pick_n),
        .zero_o (pick_z)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = lane_res[sel];
        st_d.c   = lane_c[sel];
        if (op_known) begin
            st_d.n = pick_n;
            st_d.z = pick_z;
            st_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign flag_c_o = st_q.c;
    assign flag_n_o = st_q.n;
    assign flag_z_o = st_q.z;
    assign flag_v_o = st_q.v;

endmodule

// File: rtl/ssr_unit_chk.sv
module ssr_unit_chk #(
    parameter int DATA_W = ssr_pkg::SSR_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        size_i,
    input logic [3:0]        op_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] res_o,
    input logic              flag_c_o,
    input logic              flag_n_o,
    input logic              flag_z_o,
    input logic              flag_v_o
);
    localparam int BYTE_W = DATA_W / 4;

    p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |=> (res_o[DATA_W-1:BYTE_W] == '0));

    p_shl_byte_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 && size_i == 2'd0) |=> (flag_c_o == $past(opnd_i[BYTE_W-1])));

    p_shr_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |=> (flag_c_o == $past(opnd_i[0])));

    p_invert_keeps_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0) |=> (flag_c_o == $past(carry_i)));

    p_v_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd8) |=> !flag_v_o);

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= 4'd8) |=> (flag_z_o == (res_o == '0)));

    p_unused_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8) |=> ($stable(flag_n_o) && $stable(flag_z_o) && $stable(flag_v_o)));

endmodule

bind ssr_unit ssr_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ssr_unit.sv
module test_ssr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [1:0]  size_i = '0;
    logic [3:0]  op_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] res_o;
    logic        flag_c_o, flag_n_o, flag_z_o, flag_v_o;

    int checks = 0;
    int errors = 0;
    logic m_n = 1'b0, m_z = 1'b0, m_v = 1'b0;

    always #10 clk = ~clk;

    ssr_unit i_ssr_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .opnd_i   (opnd_i),
        .size_i   (size_i),
        .op_i     (op_i),
        .carry_i  (carry_i),
        .res_o    (res_o),
        .flag_c_o (flag_c_o),
        .flag_n_o (flag_n_o),
        .flag_z_o (flag_z_o),
        .flag_v_o (flag_v_o)
    );

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0:             return "R7";
            4'd1, 4'd3:       return "R3";
            4'd2, 4'd4:       return "R4";
            4'd5, 4'd6:       return "R5";
            4'd7, 4'd8:       return "R6";
            default:          return "R9";
        endcase
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // called on a falling edge; checks on the next falling edge
    task automatic run_op(input logic [3:0] op, input logic [1:0] sz,
                          input logic [31:0] a_raw, input logic cin);
        int w;
        logic [31:0] m, a, r;
        logic msb, lsb, c, n, z, v;
        string tg;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        a = a_raw & m;
        msb = a[w-1];
        lsb = a[0];
        c = cin;
        case (op)
            4'd0: r = ~a & m;
            4'd1, 4'd3: begin r = (a << 1) & m; c = msb; end
            4'd2: begin r = a >> 1; c = lsb; end
            4'd4: begin r = (a >> 1) | ({31'b0, msb} << (w-1)); c = lsb; end
            4'd5: begin r = ((a << 1) | {31'b0, msb}) & m; c = msb; end
            4'd6: begin r = (a >> 1) | ({31'b0, lsb} << (w-1)); c = lsb; end
            4'd7: begin r = ((a << 1) | {31'b0, cin}) & m; c = msb; end
            4'd8: begin r = (a >> 1) | ({31'b0, cin} << (w-1)); c = lsb; end
            default: r = a;
        endcase
        if (op <= 4'd8) begin
            n = r[w-1];
            z = (r == 32'd0);
            v = 1'b0;
        end else begin
            n = m_n; z = m_z; v = m_v;
        end
        opnd_i = a_raw; size_i = sz; op_i = op; carry_i = cin;
        @(negedge clk);
        tg = op_tag(op);
        checks++;
        if (res_o !== r) begin
            errors++;
            $display("FAIL %s/R2 op=%0d size=%0d result actual=%h expected=%h",
                     tg, op, sz, res_o, r);
        end
        checks++;
        if (flag_c_o !== c) begin
            errors++;
            $display("FAIL %s carry op=%0d actual=%b expected=%b", tg, op, flag_c_o, c);
        end
        checks++;
        if ({flag_n_o, flag_z_o, flag_v_o} !== {n, z, v}) begin
            errors++;
            $display("FAIL %s R8 nzv op=%0d actual=%b%b%b expected=%b%b%b",
                     tg, op, flag_n_o, flag_z_o, flag_v_o, n, z, v);
        end
        m_n = n; m_z = z; m_v = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({res_o, flag_c_o, flag_n_o, flag_z_o, flag_v_o} !== 36'd0) begin
            errors++;
            $display("FAIL R1 reset actual=%h expected=0",
                     {res_o, flag_c_o, flag_n_o, flag_z_o, flag_v_o});
        end
        rst_n = 1'b1;
        // R3 byte top bit into C, upper bits dropped (R2)
        run_op(4'd1, 2'd0, 32'hFFFF_FF81, 1'b0);
        run_op(4'd3, 2'd1, 32'h0000_8000, 1'b0);
        // R4 arithmetic right keeps sign
        run_op(4'd4, 2'd1, 32'h0000_8001, 1'b0);
        run_op(4'd2, 2'd2, 32'h8000_0001, 1'b1);
        // R5 plain rotates
        run_op(4'd5, 2'd0, 32'h0000_0080, 1'b0);
        run_op(4'd6, 2'd3, 32'h0000_0001, 1'b0);
        // R6 rotate through carry
        run_op(4'd7, 2'd2, 32'h8000_0000, 1'b1);
        run_op(4'd8, 2'd0, 32'h0000_0000, 1'b1);
        // R7 complement, C from carry_i, Z set
        run_op(4'd0, 2'd0, 32'h0012_34FF, 1'b1);
        run_op(4'd0, 2'd1, 32'h0000_0000, 1'b0);
        // R9 unused codes hold N Z V, pass operand masked
        run_op(4'd2, 2'd0, 32'h0000_0001, 1'b0);
        run_op(4'd9, 2'd0, 32'h1234_5678, 1'b1);
        run_op(4'd15, 2'd1, 32'hABCD_8000, 1'b0);
        run_op(4'd4, 2'd2, 32'h8000_0000, 1'b0);
        run_op(4'd12, 2'd2, 32'h0000_0000, 1'b1);
        // mixed patterns, back to back
        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                   $urandom(), 1'($urandom_range(0, 1)));
        end
        summary();
    end

endmodule